// File: doc/BRIEF.md
# Chainable Multi-Channel System Timer

This block is a bank of independent down-counting timer channels behind a small write/read register bus. Software programs each channel with a reload value and a control word. The control word chooses between free-running and one-shot operation, turns the interrupt flag and the event pulse on or off, and can link the channel to the channel below it. A channel starts on a command write or on a pulse at its hardware start input. When it expires, it can set a sticky interrupt flag, emit a one-cycle event pulse, or do both.

Linking neighbouring channels makes one wider counter. A linked channel advances only when the channel beneath it wraps. Only the uppermost channel of a linked group reports expiry, so a group of all six 16-bit channels forms a 96-bit counter with a single completion signal.

Top module: `chain_timer_bank`

## Requirements
- R1: After synchronous reset, every counter reads 0, no channel is running, the interrupt status is 0, and `irq_o` and `evt_o` are low.
- R2: Writing the command register with bit 0 set loads the reload value and starts the channel. The channel expires reload+1 clock cycles after the clock edge that took the write.
- R3: In one-shot mode (control bit 0 = 0), the channel stops at its first expiry and its counter stays at 0.
- R4: In free-running mode (control bit 0 = 1), the channel reloads in the same cycle it expires, stays running, and expires again every reload+1 cycles.
- R5: A one-cycle pulse on `start_evt_i[n]` starts channel n exactly as a software start does.
- R6: On expiry, the status bit of the channel is set only if interrupt enable (control bit 1) is 1. Status bits hold until they are cleared, and `irq_o` mirrors the status register.
- R7: On expiry, `evt_o[n]` is high for one cycle only if event enable (control bit 2) is 1. The pulse appears in the cycle after the expiring edge.
- R8: Writing 1 to a bit of the status register (address 24) clears that bit. An expiry in the same cycle as the clear keeps the bit set.
- R9: A command write with bit 1 set stops the channel without raising an expiry. When bit 0 and bit 1 are both set, the stop wins.
- R10: When control bit 3 of channel n (n>0) is set, channel n counts only in cycles where channel n-1 wraps. The linked pair expires after (Hn+1)*(Ln-1+1) cycles. The expiry of channel n-1 then sets no status bit and gives no event pulse.
- R11: Register map: address = channel*4 + register, with 0 = control, 1 = reload, 2 = command (write-only, reads 0), 3 = counter (read-only). Address 24 is the status register and address 25 is the running mask. `bus_rdata` is registered and shows the addressed register one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for `bus_addr` |
| start_evt_i | input | 6 | Per-channel hardware start pulse |
| irq_o | output | 6 | Sticky interrupt status per channel |
| evt_o | output | 6 | One-cycle expiry event per channel |

## Verification
The hardest case to reach from the ports is a linked pair in which the upper channel has to hold still through several wraps of the lower one. This must happen while the lower channel's own enabled interrupt stays masked. The stimulus loads the upper channel first and only then starts the lower one. It then samples the interrupt lines on every cycle up to the product period. Precise timing is checked in the same way for the free-running event pulse, the start pulse, and a clear that collides with a set on a reload-0 free-running channel.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic chain;
    logic evt_en;
    logic irq_en;
    logic cont;
  } tmr_ctrl_t;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_RELOAD = 2'd1;
  localparam logic [1:0] REG_CMD    = 2'd2;
  localparam logic [1:0] REG_COUNT  = 2'd3;
  localparam int CMD_START_BIT = 0;
  localparam int CMD_STOP_BIT  = 1;
endpackage

// File: rtl/timer_channel.sv
module timer_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cont_i,
  input  logic          evt_en_i,
  input  logic          chained_i,
  input  logic          report_i,
  input  logic [CW-1:0] reload_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          lower_wrap_i,
  output logic [CW-1:0] count_o,
  output logic          running_o,
  output logic          wrap_o,
  output logic          expire_o,
  output logic          evt_o
);
  logic [CW-1:0] count_q;
  logic          running_q;
  logic          evt_q;
  logic          tick;
  logic          wrap;

  assign tick = running_q && (!chained_i || lower_wrap_i);
  assign wrap = tick && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q   <= '0;
      running_q <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      evt_q <= wrap && report_i && evt_en_i;
      if (stop_i) begin
        running_q <= 1'b0;
      end else if (start_i) begin
        running_q <= 1'b1;
        count_q   <= reload_i;
      end else if (tick) begin
        if (count_q == '0) begin
          if (cont_i) count_q <= reload_i;
          else        running_q <= 1'b0;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
    end
  end

  assign count_o   = count_q;
  assign running_o = running_q;
  assign wrap_o    = wrap;
  assign expire_o  = wrap && report_i;
  assign evt_o     = evt_q;

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!running_q && (stop_i || !start_i)) |=> $stable(count_q));
  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !running_q);
  assert_single_stops_R3: assert property (@(posedge clk) disable iff (rst)
    (wrap && !cont_i && !start_i) |=> !running_q);
  assert_cont_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (wrap && cont_i && !start_i && !stop_i) |=> (running_q && count_q == $past(reload_i)));
  assert_chain_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (running_q && chained_i && !lower_wrap_i && !start_i && !stop_i) |=> $stable(count_q));
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import tmr_pkg::*;
#(
  parameter int NCH = 6,
  parameter int CW  = 16,
  parameter int AW  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [CW-1:0]   bus_wdata,
  output logic [CW-1:0]   bus_rdata,
  output tmr_ctrl_t       ctrl_o   [NCH],
  output logic [CW-1:0]   reload_o [NCH],
  output logic [NCH-1:0]  start_o,
  output logic [NCH-1:0]  stop_o,
  input  logic [NCH-1:0]  irq_set_i,
  input  logic [NCH-1:0]  running_i,
  input  logic [CW-1:0]   count_i  [NCH],
  output logic [NCH-1:0]  status_o
);
  localparam int CHW = AW - 2;

  logic [CHW-1:0] ch_sel;
  logic [1:0]     reg_sel;
  logic           glb_sel;
  logic [NCH-1:0] clr_vec;
  logic [NCH-1:0] status_q;
  logic [CW-1:0]  rd_nxt;
  logic [CW-1:0]  rdata_q;
  tmr_ctrl_t      ctrl_q   [NCH];
  logic [CW-1:0]  reload_q [NCH];

  assign ch_sel  = bus_addr[AW-1:2];
  assign reg_sel = bus_addr[1:0];
  assign glb_sel = (ch_sel == CHW'(NCH));
  assign clr_vec = (bus_we && glb_sel && reg_sel == 2'd0) ? bus_wdata[NCH-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_chreg
    logic hit;
    assign hit = bus_we && (ch_sel == CHW'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[i]   <= '0;
        reload_q[i] <= '0;
      end else begin
        if (hit && reg_sel == REG_CTRL)   ctrl_q[i]   <= tmr_ctrl_t'(bus_wdata[3:0]);
        if (hit && reg_sel == REG_RELOAD) reload_q[i] <= bus_wdata;
      end
    end
    assign start_o[i]  = hit && reg_sel == REG_CMD && bus_wdata[CMD_START_BIT];
    assign stop_o[i]   = hit && reg_sel == REG_CMD && bus_wdata[CMD_STOP_BIT];
    assign ctrl_o[i]   = ctrl_q[i];
    assign reload_o[i] = reload_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr_vec) | irq_set_i;
  end

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_sel == CHW'(i)) begin
        case (reg_sel)
          REG_CTRL:   rd_nxt = CW'(ctrl_q[i]);
          REG_RELOAD: rd_nxt = reload_q[i];
          REG_COUNT:  rd_nxt = count_i[i];
          default:    rd_nxt = '0;
        endcase
      end
    end
    if (glb_sel) begin
      if (reg_sel == 2'd0)      rd_nxt = CW'(status_q);
      else if (reg_sel == 2'd1) rd_nxt = CW'(running_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_nxt;
  end

  assign bus_rdata = rdata_q;
  assign status_o  = status_q;

  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec & ~irq_set_i) != '0) |=> ((status_q & $past(clr_vec & ~irq_set_i)) == '0));
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_vec == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_set_i != '0) |=> ((status_q & $past(irq_set_i)) == $past(irq_set_i)));
endmodule

// File: rtl/chain_timer_bank.sv
module chain_timer_bank
  import tmr_pkg::*;
#(
  parameter int NCH = 6,
  parameter int CW  = 16,
  parameter int AW  = $clog2(NCH + 1) + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  input  logic [NCH-1:0] start_evt_i,
  output logic [NCH-1:0] irq_o,
  output logic [NCH-1:0] evt_o
);
  tmr_ctrl_t      ctrl_w   [NCH];
  logic [CW-1:0]  reload_w [NCH];
  logic [CW-1:0]  count_w  [NCH];
  logic [NCH-1:0] sw_start, sw_stop, running_w, wrap_w, expire_w, irq_set_w;

  timer_regs #(.NCH(NCH), .CW(CW), .AW(AW)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl_o    (ctrl_w),
    .reload_o  (reload_w),
    .start_o   (sw_start),
    .stop_o    (sw_stop),
    .irq_set_i (irq_set_w),
    .running_i (running_w),
    .count_i   (count_w),
    .status_o  (irq_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic lower_wrap, chained, report;
    if (i == 0) begin : g_base
      assign lower_wrap = 1'b0;
      assign chained    = 1'b0;
    end else begin : g_linked
      assign lower_wrap = wrap_w[i-1];
      assign chained    = ctrl_w[i].chain;
    end
    if (i == NCH - 1) begin : g_top
      assign report = 1'b1;
    end else begin : g_mid
      assign report = !ctrl_w[i+1].chain;
    end

    timer_channel #(.CW(CW)) ch_i (
      .clk          (clk),
      .rst          (rst),
      .cont_i       (ctrl_w[i].cont),
      .evt_en_i     (ctrl_w[i].evt_en),
      .chained_i    (chained),
      .report_i     (report),
      .reload_i     (reload_w[i]),
      .start_i      (sw_start[i] | start_evt_i[i]),
      .stop_i       (sw_stop[i]),
      .lower_wrap_i (lower_wrap),
      .count_o      (count_w[i]),
      .running_o    (running_w[i]),
      .wrap_o       (wrap_w[i]),
      .expire_o     (expire_w[i]),
      .evt_o        (evt_o[i])
    );
    assign irq_set_w[i] = expire_w[i] && ctrl_w[i].irq_en;
  end
endmodule

// File: tb/chain_timer_bank_tb.sv
module chain_timer_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int CW  = 16;
  localparam int AW  = 5;
  localparam int WDOG = 100000;
  localparam int NV  = 20;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_WT = 2'd2;

  // entry: {req[3:0], kind[1:0], addr[5:0], data[15:0]}
  localparam logic [27:0] VEC [NV] = '{
    {4'd11, K_WR, 6'd8,  16'h0002},  // R11 ch2 ctrl: irq only, one-shot
    {4'd11, K_WR, 6'd9,  16'h0005},
    {4'd11, K_RD, 6'd9,  16'h0005},  // R11 reload readback
    {4'd11, K_RD, 6'd8,  16'h0002},  // R11 ctrl readback
    {4'd2,  K_WR, 6'd10, 16'h0001},  // R2 start ch2
    {4'd2,  K_WT, 6'd0,  16'd20},
    {4'd3,  K_RD, 6'd24, 16'h0004},  // R3/R6 status bit2
    {4'd3,  K_RD, 6'd25, 16'h0000},  // R3 stopped
    {4'd3,  K_RD, 6'd11, 16'h0000},  // R3 count held at 0
    {4'd8,  K_WR, 6'd24, 16'h0004},  // R8 clear
    {4'd8,  K_RD, 6'd24, 16'h0000},
    {4'd4,  K_WR, 6'd12, 16'h0001},  // R4 ch3 free-running, no irq
    {4'd4,  K_WR, 6'd13, 16'h0003},
    {4'd4,  K_WR, 6'd14, 16'h0001},
    {4'd4,  K_WT, 6'd0,  16'd10},
    {4'd4,  K_RD, 6'd25, 16'h0008},  // R4 still running
    {4'd6,  K_RD, 6'd24, 16'h0000},  // R6 irq disabled
    {4'd9,  K_WR, 6'd14, 16'h0002},  // R9 stop
    {4'd9,  K_RD, 6'd25, 16'h0000},
    {4'd11, K_RD, 6'd12, 16'h0001}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic [NCH-1:0] start_evt_i = '0;
  logic [NCH-1:0] irq_o, evt_o;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [CW-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_timer_bank #(.NCH(NCH), .CW(CW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .start_evt_i(start_evt_i), .irq_o(irq_o), .evt_o(evt_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", 32'(irq_o), 32'h0);
    chk("R1 evt", 32'(evt_o), 32'h0);
    rd(5'd24, rv); chk("R1 status", 32'(rv), 32'h0);
    rd(5'd25, rv); chk("R1 running", 32'(rv), 32'h0);
    rd(5'd3,  rv); chk("R1 count", 32'(rv), 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [27:0] e;
      string tag;
      e = VEC[v];
      tag = $sformatf("R%0d vec%0d", e[27:24], v);
      case (e[23:22])
        K_WR: wr(e[20:16], e[15:0]);
        K_RD: begin rd(e[20:16], rv); chk(tag, 32'(rv), 32'(e[15:0])); end
        default: idle(int'(e[15:0]));
      endcase
    end

    // R2 / R7: ch0 free-running, event only, reload 3
    wr(5'd0, 16'h0005);
    wr(5'd1, 16'd3);
    wr(5'd2, 16'h0001);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R2 R7 evt timing", 32'(evt_o[0]), 32'((k == 4) || (k == 8)));
    end
    chk("R6 no irq without enable", 32'(irq_o[0]), 32'h0);
    wr(5'd2, 16'h0002);

    // R5: hardware start of ch4, one-shot irq, reload 2
    wr(5'd16, 16'h0002);
    wr(5'd17, 16'd2);
    @(negedge clk); start_evt_i[4] = 1'b1;
    @(negedge clk); start_evt_i[4] = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk("R5 event start", 32'(irq_o[4]), 32'(k == 3));
    end
    rd(5'd25, rv); chk("R5 R3 stopped", 32'(rv), 32'h0);
    wr(5'd24, 16'h0010);

    // R9: stop beats start, stop mid-run raises nothing
    wr(5'd20, 16'h0002);
    wr(5'd21, 16'd10);
    wr(5'd22, 16'h0003);
    rd(5'd25, rv); chk("R9 stop wins", 32'(rv), 32'h0);
    wr(5'd22, 16'h0001);
    idle(3);
    wr(5'd22, 16'h0002);
    idle(20);
    rd(5'd24, rv); chk("R9 no expiry", 32'(rv), 32'h0);

    // R8: clear collides with set on reload-0 free-running ch3
    wr(5'd12, 16'h0003);
    wr(5'd13, 16'd0);
    wr(5'd14, 16'h0001);
    idle(2);
    wr(5'd24, 16'h0008);
    rd(5'd24, rv); chk("R8 set wins", 32'(rv), 32'h0008);
    wr(5'd14, 16'h0002);
    wr(5'd24, 16'h0008);
    rd(5'd24, rv); chk("R8 clear", 32'(rv), 32'h0);

    // R10: ch1 linked over ch0; L=2, H=1 -> 6 cycles
    wr(5'd0, 16'h0003);
    wr(5'd1, 16'd2);
    wr(5'd4, 16'h000A);
    wr(5'd5, 16'd1);
    wr(5'd6, 16'h0001);
    wr(5'd2, 16'h0001);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R10 chained expiry", 32'(irq_o[1]), 32'(k == 6));
      chk("R10 lower suppressed", 32'(irq_o[0]), 32'h0);
    end
    rd(5'd25, rv); chk("R10 running mask", 32'(rv), 32'h0001);
    wr(5'd2, 16'h0002);

    finish_run();
  end
endmodule